// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the interrupt status and control word that sits beside a bank of DMA channels. It keeps one completion flag per channel, a per-channel enable that decides whether that channel's completion is recorded, a global enable, a force bit for bus errors, and a small scratch field of general control bits. From these it derives a master interrupt bit. Whenever that bit goes from clear to set, the block sends a one-cycle pulse to the system interrupt controller, where the pulse lands on status bit 3.

Software reaches the word through a simple write port at one fixed offset. Half-word writes at that offset count as full word writes. Control fields take the written value as it stands. A flag is cleared by writing a one to its position. The read port always shows the current word. Each DMA channel drives a one-cycle completion pulse into the block.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, and while reset is held, the read value is 0x00000000 and no interrupt pulse is given.
- R2: A write at offset 0x10F4 loads exactly the bits in mask 0x00FF803F. Those are the scratch bits 5..0, the bus-error force bit 15, the channel enables 23..16 (bit 23 is the global enable), and nothing else. Bits 14..6 always read zero. A write at any other offset changes nothing.
- R3: A half-word write (bus_half=1) at the offset acts as a full 32-bit write, and the upper bits are taken from bus_wdata[31:16].
- R4: A completion pulse on channel n sets flag bit 24+n only if enable bit 16+n was already set before that clock edge. Otherwise the pulse is dropped.
- R5: Writing 1 to flag bit 24+n clears that flag, and writing 0 leaves it as it was. If a completion pulse arrives in the same cycle as the clearing write, the flag ends up set.
- R6: Bit 31 reads as (bit 23 AND any of bits 30..24) OR bit 15. It is recomputed after every write and every completion pulse, and writing bit 31 has no effect.
- R7: irq_pulse is high for exactly one cycle, in the cycle in which bit 31 first reads 1 after having been 0. It stays low while bit 31 stays set or falls.
- R8: A completion pulse on channel n changes only flag n. Both the lowest channel (0) and the highest channel (6) map to their own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_half | input | 1 | Write is half-word sized |
| bus_addr | input | 16 | Write offset |
| bus_wdata | input | 32 | Write data |
| ch_done | input | 7 | Per-channel completion pulses |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle request to the interrupt controller |

## Verification
The master bit is driven in three ways: through the bus-error force bit alone, through an enabled channel completion under the global enable, and by turning the global enable on while a flag is already pending. This separates the three paths that can set bit 31. Same-cycle clear-and-complete, completions on channels that are not enabled, writes to a neighbouring offset and half-word writes each check one update rule against its neighbours. Sequences in which bit 31 stays set across further writes show whether the pulse follows the edge of bit 31 or only its level.

// File: rtl/dma_irq_ctrl_pkg.sv
package dma_irq_ctrl_pkg;
   localparam int REG_W    = 32;
   localparam int MAX_CH   = 7;
   localparam int BERR_BIT = 15;
   localparam int ENA_LSB  = 16;
   localparam int GEN_BIT  = 23;
   localparam int FLG_LSB  = 24;
   localparam int MST_BIT  = 31;

   // Mask of the bits a write loads directly.
   function automatic logic [REG_W-1:0] direct_mask(input int low_w, input int nch);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < low_w; i++) m[i] = 1'b1;
      for (int i = 0; i < nch; i++) m[ENA_LSB+i] = 1'b1;
      m[BERR_BIT] = 1'b1;
      m[GEN_BIT]  = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/dma_irq_wr_decode.sv
module dma_irq_wr_decode #(
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] REG_OFFSET = 16'h10F4,
   parameter bit          WIDEN_HALF = 1'b1
) (
   input  logic              bus_wr,
   input  logic              bus_half,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

   logic addr_match;
   assign addr_match = (bus_addr == OFS);

   generate
      if (WIDEN_HALF) begin : g_widen
         // Half-word stores count as full word stores.
         assign hit = bus_wr & addr_match;
      end else begin : g_word_only
         assign hit = bus_wr & addr_match & ~bus_half;
      end
   endgenerate

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dma_irq_wr_decode: ADDR_W too small");
      end
   endgenerate
endmodule

// File: rtl/dma_irq_flag_cell.sv
module dma_irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic en,
   input  logic ack,
   output logic flag_d,
   output logic flag_q
);
   logic set_req;
   assign set_req = done & en;

   // A completion wins over a clearing write in the same cycle.
   always_comb begin
      if (set_req)  flag_d = 1'b1;
      else if (ack) flag_d = 1'b0;
      else          flag_d = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   a_r4_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(done) && $past(en));
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(done && en)) |=> !flag_q);
   a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && !done) |=> $stable(flag_q));
endmodule

// File: rtl/dma_irq_master.sv
module dma_irq_master #(
   parameter int NUM_CH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              berr_d,
   input  logic              gen_d,
   input  logic [NUM_CH-1:0] flags_d,
   output logic              master_q,
   output logic              irq_pulse
);
   logic master_d;
   assign master_d = berr_d | (gen_d & (|flags_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q  <= 1'b0;
         irq_pulse <= 1'b0;
      end else begin
         master_q  <= master_d;
         irq_pulse <= master_d & ~master_q;
      end
   end

   a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> master_q && !$past(master_q));
   a_r7_rise_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(master_q) |-> irq_pulse);
   a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
   import dma_irq_ctrl_pkg::*;
#(
   parameter int          NUM_CH     = 7,
   parameter int          LOW_W      = 6,
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] REG_OFFSET = 16'h10F4,
   parameter bit          WIDEN_HALF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_half,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [NUM_CH-1:0] ch_done,
   output logic [31:0]       rd_data,
   output logic              irq_pulse
);
   localparam logic [REG_W-1:0] WMASK = direct_mask(LOW_W, NUM_CH);

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("dma_irq_ctrl: NUM_CH out of range");
      end
      if (LOW_W < 1 || LOW_W > BERR_BIT) begin : g_bad_low
         $error("dma_irq_ctrl: LOW_W out of range");
      end
   endgenerate

   logic              hit;
   logic [LOW_W-1:0]  low_q;
   logic              berr_q, gen_q;
   logic [NUM_CH-1:0] ena_q;
   logic              berr_d, gen_d;
   logic [NUM_CH-1:0] ack, flags_d, flags_q;
   logic              master_q;

   dma_irq_wr_decode #(
      .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .WIDEN_HALF(WIDEN_HALF)
   ) u_dec (
      .bus_wr(bus_wr), .bus_half(bus_half), .bus_addr(bus_addr), .hit(hit)
   );

   assign berr_d = hit ? bus_wdata[BERR_BIT] : berr_q;
   assign gen_d  = hit ? bus_wdata[GEN_BIT]  : gen_q;
   assign ack    = hit ? bus_wdata[FLG_LSB +: NUM_CH] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         berr_q <= 1'b0;
         gen_q  <= 1'b0;
         ena_q  <= '0;
      end else if (hit) begin
         low_q  <= bus_wdata[LOW_W-1:0];
         berr_q <= bus_wdata[BERR_BIT];
         gen_q  <= bus_wdata[GEN_BIT];
         ena_q  <= bus_wdata[ENA_LSB +: NUM_CH];
      end
   end

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         dma_irq_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .done(ch_done[n]), .en(ena_q[n]), .ack(ack[n]),
            .flag_d(flags_d[n]), .flag_q(flags_q[n])
         );
      end
   endgenerate

   dma_irq_master #(.NUM_CH(NUM_CH)) u_master (
      .clk(clk), .rst_n(rst_n),
      .berr_d(berr_d), .gen_d(gen_d), .flags_d(flags_d),
      .master_q(master_q), .irq_pulse(irq_pulse)
   );

   always_comb begin
      rd_data                    = '0;
      rd_data[LOW_W-1:0]         = low_q;
      rd_data[BERR_BIT]          = berr_q;
      rd_data[ENA_LSB +: NUM_CH] = ena_q;
      rd_data[GEN_BIT]           = gen_q;
      rd_data[FLG_LSB +: NUM_CH] = flags_q;
      rd_data[MST_BIT]           = master_q;
   end

   // R6: the registered master bit agrees with the registered fields.
   a_r6_master_tracks_fields: assert property (@(posedge clk) disable iff (!rst_n)
      master_q == (berr_q | (gen_q & (|flags_q))));
   // R2: bits outside the loadable fields and the flags stay zero.
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~WMASK & 32'h00FF_FFFF) == '0);
   // R2: a write elsewhere leaves the control fields alone.
   a_r2_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(ena_q) && $stable(gen_q) && $stable(berr_q) && $stable(low_q));
endmodule

// File: tb/test_dma_irq_ctrl.sv
module test_dma_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_half = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [6:0]  ch_done = '0;
   logic [31:0] rd_data;
   logic        irq_pulse;

   int n_cmp = 0, n_bad = 0;

   always #5 clk = ~clk;

   dma_irq_ctrl i_dma_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_half(bus_half),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ch_done(ch_done),
      .rd_data(rd_data), .irq_pulse(irq_pulse)
   );

   // Layout: wr, half, addr[16], wdata[32], done[7], exp_rd[32], exp_pulse
   localparam int NV = 16;
   localparam logic [89:0] VEC [NV] = '{
      {1'b1,1'b0,16'h10F4,32'hFFFF_FFFF,7'h00,32'h80FF_803F,1'b1}, // R2 R6 R7 force bit
      {1'b1,1'b0,16'h10F4,32'h0000_0000,7'h00,32'h0000_0000,1'b0}, // R6 falls
      {1'b1,1'b0,16'h10F4,32'h0081_0000,7'h00,32'h0081_0000,1'b0}, // R2
      {1'b0,1'b0,16'h0000,32'h0000_0000,7'h01,32'h8181_0000,1'b1}, // R4 R7
      {1'b0,1'b0,16'h0000,32'h0000_0000,7'h02,32'h8181_0000,1'b0}, // R4 disabled
      {1'b1,1'b0,16'h10F4,32'h0081_0000,7'h00,32'h8181_0000,1'b0}, // R5 zero keeps
      {1'b1,1'b0,16'h10F4,32'h0181_0000,7'h00,32'h0081_0000,1'b0}, // R5 ack
      {1'b1,1'b0,16'h10F0,32'hFFFF_FFFF,7'h00,32'h0081_0000,1'b0}, // R2 other offset
      {1'b1,1'b1,16'h10F4,32'h00C2_0000,7'h00,32'h00C2_0000,1'b0}, // R3 half
      {1'b0,1'b0,16'h0000,32'h0000_0000,7'h02,32'h82C2_0000,1'b1}, // R8 ch1
      {1'b1,1'b0,16'h10F4,32'h0242_0000,7'h02,32'h0242_0000,1'b0}, // R5 set wins
      {1'b1,1'b0,16'h10F4,32'h00C2_0000,7'h00,32'h82C2_0000,1'b1}, // R6 enable late
      {1'b1,1'b0,16'h10F4,32'h8000_0000,7'h00,32'h0200_0000,1'b0}, // R6 bit31 ro
      {1'b1,1'b0,16'h10F4,32'h0000_8000,7'h00,32'h8200_8000,1'b1}, // R6 force
      {1'b1,1'b0,16'h10F4,32'h0200_803F,7'h00,32'h8000_803F,1'b0}, // R7 stays set
      {1'b0,1'b0,16'h0000,32'h0000_0000,7'h7F,32'h8000_803F,1'b0}  // R4 none enabled
   };
   localparam int VREQ [NV] = '{2,6,2,4,4,5,5,2,3,8,5,6,6,6,7,4};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic half, input logic [15:0] a,
                       input logic [31:0] d, input logic [6:0] dn);
      @(negedge clk);
      bus_wr = wr; bus_half = half; bus_addr = a; bus_wdata = d; ch_done = dn;
      @(posedge clk);
      #1;
      bus_wr = 1'b0; bus_half = 1'b0; bus_addr = '0; bus_wdata = '0; ch_done = '0;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset value", rd_data, 32'h0);
      check("R1 reset pulse", {31'h0, irq_pulse}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][89], VEC[i][88], VEC[i][87:72], VEC[i][71:40], VEC[i][39:33]);
         check($sformatf("R%0d vec%0d rd", VREQ[i], i), rd_data, VEC[i][32:1]);
         check($sformatf("R%0d vec%0d pulse", VREQ[i], i), {31'h0, irq_pulse}, {31'h0, VEC[i][0]});
      end

      // R7: idle cycle while bit 31 stays set gives no pulse.
      step(1'b0, 1'b0, 16'h0, 32'h0, 7'h00);
      check("R7 hold no pulse", {31'h0, irq_pulse}, 32'h0);
      // R8: highest channel.
      step(1'b1, 1'b0, 16'h10F4, 32'h00C0_0000, 7'h00);
      check("R8 ch6 setup", rd_data, 32'h00C0_0000);
      step(1'b0, 1'b0, 16'h0, 32'h0, 7'h40);
      check("R8 ch6 flag", rd_data, 32'hC0C0_0000);
      check("R8 ch6 pulse", {31'h0, irq_pulse}, 32'h1);
      step(1'b0, 1'b0, 16'h0, 32'h0, 7'h00);
      check("R7 one cycle", {31'h0, irq_pulse}, 32'h0);
      // R1: reset in the middle of operation.
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1 mid reset value", rd_data, 32'h0);
      @(posedge clk);
      #1;
      check("R1 mid reset pulse", {31'h0, irq_pulse}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule